// File: doc/BRIEF.md
# SIMD Lane Condition and Masked-Move Unit

This block serves a SIMD datapath with LANES lanes of W bits each. It has two jobs. The first is to evaluate one condition per lane on two vector operands, using either an ordering comparison or a bit test. The one-bit lane results are packed into a condition word that is LANES bits wide. That word can be kept in a scalar register and tested for zero by loop-control logic. The second job is to take a condition word and perform a masked move. Selected lanes of a source vector replace the matching lanes of an old destination vector, and every other lane keeps its old value.

Each request is accepted when `in_valid` is high. The result appears one clock later, together with a one-cycle `out_valid` pulse. Two flags are computed from the packed word and registered with it: all-false and any-true. Branch logic can use them directly, for example to run a loop until every lane reports false.

Top module: `simd_cond_unit`

## Requirements
- R1: Opcodes 0 to 5 compare each lane's `src_a` element with its `src_b` element: 0 is less-than, 1 is less-or-equal, 2 is greater-than, 3 is greater-or-equal, 4 is not-equal, 5 is equal. When `is_signed` is 1 the ordering tests treat elements as two's complement; when it is 0 they treat them as unsigned.
- R2: Opcodes 6 to 9 are bit tests on each lane: 6 is true when the `src_a` element is zero, 7 when it is non-zero, 8 when (`src_a` AND `src_b`) is zero, and 9 when (`src_a` AND `src_b`) is non-zero.
- R3: Bit i of `cond_out` is the result of lane i, and lane i occupies bits [i*W +: W] of every vector port.
- R4: Opcode 10 is the masked move. When `inv` is 0, each lane of `move_out` takes `src_a` where bit i of `cond_in` is 1 and takes `dst_old` where it is 0.
- R5: For opcode 10 with `inv` = 1 the selection is reversed: lanes whose bit in `cond_in` is 0 take `src_a`, and lanes whose bit is 1 keep `dst_old`.
- R6: `cond_zero` is 1 exactly when `cond_out` is all zero, and `cond_any` is always the complement of `cond_zero`.
- R7: Results are registered. `out_valid` is high in the cycle after every cycle in which `in_valid` was high, and low in every other cycle.
- R8: While `in_valid` is low, `cond_out`, `move_out` and the flags keep their previous values whatever the other inputs do.
- R9: For opcodes 0 to 9, `move_out` equals `dst_old` and `inv` has no effect. For opcode 10, `cond_out` echoes `cond_in`. Opcodes 11 to 15 give a `cond_out` of zero and a `move_out` equal to `dst_old`.
- R10: During reset `out_valid` is 0, `cond_out` and `move_out` are zero, `cond_zero` is 1 and `cond_any` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A request is presented this cycle |
| op | input | 4 | Operation code |
| is_signed | input | 1 | Ordering tests use two's complement |
| inv | input | 1 | Masked move selects lanes whose mask bit is 0 |
| src_a | input | LANES*W | First operand, and the move source |
| src_b | input | LANES*W | Second operand |
| dst_old | input | LANES*W | Previous destination vector |
| cond_in | input | LANES | Mask word for the masked move |
| out_valid | output | 1 | Result registered this cycle |
| cond_out | output | LANES | Packed per-lane condition word |
| move_out | output | LANES*W | Masked-move result vector |
| cond_zero | output | 1 | Condition word is all false |
| cond_any | output | 1 | At least one lane is true |

## Verification
The bench builds the unit with LANES = 4 and W = 3. At that size there are only 64 possible operand pairs per lane, so each opcode/signedness combination covers every pair in 16 requests of four lanes. This reaches every signed wrap point, such as 3 against -4, and every bit-test overlap. The four-lane mask has only 16 values, so the masked move is run under every mask with both polarities of `inv`. The reserved opcodes and the hold behaviour are checked at the same small size.

// File: rtl/simd_cond_pkg.sv
package simd_cond_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LT   = 4'd0,
    OP_LE   = 4'd1,
    OP_GT   = 4'd2,
    OP_GE   = 4'd3,
    OP_NE   = 4'd4,
    OP_EQ   = 4'd5,
    OP_AZ   = 4'd6,
    OP_ANZ  = 4'd7,
    OP_ABZ  = 4'd8,
    OP_ABNZ = 4'd9,
    OP_MOVE = 4'd10
  } cond_op_e;

  // True for opcodes that produce a per-lane condition (R1, R2)
  function automatic logic is_test_op(input logic [OP_W-1:0] op);
    return op <= OP_ABNZ;
  endfunction

  function automatic logic is_move_op(input logic [OP_W-1:0] op);
    return op == OP_MOVE;
  endfunction

endpackage

// File: rtl/simd_lane_test.sv
module simd_lane_test
  import simd_cond_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] op,
  input  logic            sgn,
  output logic            hit
);

  // Ordering: a strictly below b under the chosen interpretation
  function automatic logic below(input logic [W-1:0] x, input logic [W-1:0] y,
                                 input logic s);
    if (s) return $signed(x) < $signed(y);
    return x < y;
  endfunction

  logic lt_w, eq_w, and_zero_w, a_zero_w;

  always_comb begin
    lt_w       = below(a, b, sgn);
    eq_w       = (a == b);
    and_zero_w = ((a & b) == '0);
    a_zero_w   = (a == '0);
  end

  always_comb begin
    case (op)
      OP_LT:   hit = lt_w;
      OP_LE:   hit = lt_w | eq_w;
      OP_GT:   hit = ~(lt_w | eq_w);
      OP_GE:   hit = ~lt_w;
      OP_NE:   hit = ~eq_w;
      OP_EQ:   hit = eq_w;
      OP_AZ:   hit = a_zero_w;
      OP_ANZ:  hit = ~a_zero_w;
      OP_ABZ:  hit = and_zero_w;
      OP_ABNZ: hit = ~and_zero_w;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/simd_lane_select.sv
module simd_lane_select #(
  parameter int W = 16
) (
  input  logic         take_src,
  input  logic [W-1:0] src,
  input  logic [W-1:0] old,
  output logic [W-1:0] y
);

  always_comb y = take_src ? src : old;

endmodule

// File: rtl/simd_cond_unit.sv
module simd_cond_unit
  import simd_cond_pkg::*;
#(
  parameter int LANES = 32,
  parameter int W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [3:0]         op,
  input  logic               is_signed,
  input  logic               inv,
  input  logic [LANES*W-1:0] src_a,
  input  logic [LANES*W-1:0] src_b,
  input  logic [LANES*W-1:0] dst_old,
  input  logic [LANES-1:0]   cond_in,
  output logic               out_valid,
  output logic [LANES-1:0]   cond_out,
  output logic [LANES*W-1:0] move_out,
  output logic               cond_zero,
  output logic               cond_any
);

  localparam int VEC_W = LANES * W;

  logic               op_test_w;
  logic               op_move_w;
  logic [LANES-1:0]   test_word_w;
  logic [LANES-1:0]   take_mask_w;
  logic [LANES-1:0]   next_cond_w;
  logic [VEC_W-1:0]   next_move_w;
  logic               next_zero_w;

  always_comb begin
    op_test_w = is_test_op(op);
    op_move_w = is_move_op(op);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_lane_test #(.W(W)) u_test (
      .a   (src_a[i*W +: W]),
      .b   (src_b[i*W +: W]),
      .op  (op),
      .sgn (is_signed),
      .hit (test_word_w[i])
    );

    simd_lane_select #(.W(W)) u_sel (
      .take_src (take_mask_w[i]),
      .src      (src_a[i*W +: W]),
      .old      (dst_old[i*W +: W]),
      .y        (next_move_w[i*W +: W])
    );
  end

  // Effective lane mask: only the move opcode selects source lanes
  always_comb begin
    take_mask_w = op_move_w ? (cond_in ^ {LANES{inv}}) : '0;
    if (op_test_w)      next_cond_w = test_word_w;
    else if (op_move_w) next_cond_w = cond_in;
    else                next_cond_w = '0;
    next_zero_w = (next_cond_w == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cond_out  <= '0;
      move_out  <= '0;
      cond_zero <= 1'b1;
      cond_any  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cond_out  <= next_cond_w;
        move_out  <= next_move_w;
        cond_zero <= next_zero_w;
        cond_any  <= ~next_zero_w;
      end
    end
  end

endmodule

// File: rtl/simd_cond_unit_chk.sv
module simd_cond_unit_chk #(
  parameter int LANES = 32,
  parameter int W     = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [3:0]         op,
  input logic               inv,
  input logic [LANES*W-1:0] src_a,
  input logic [LANES*W-1:0] dst_old,
  input logic [LANES-1:0]   cond_in,
  input logic               out_valid,
  input logic [LANES-1:0]   cond_out,
  input logic [LANES*W-1:0] move_out,
  input logic               cond_zero,
  input logic               cond_any
);

  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cond_out) && $stable(move_out) && $stable(cond_zero)));

  p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_zero == (cond_out == '0)) && (cond_any == !cond_zero));

  p_move_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd10) |=> cond_out == $past(cond_in));

  p_test_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 4'd10) |=> move_out == $past(dst_old));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R4 and R5: each lane follows its (possibly inverted) mask bit
    p_move_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd10) |=>
        move_out[i*W +: W] == ($past(cond_in[i] ^ inv) ? $past(src_a[i*W +: W])
                                                        : $past(dst_old[i*W +: W])));
  end

endmodule

bind simd_cond_unit simd_cond_unit_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .inv       (inv),
  .src_a     (src_a),
  .dst_old   (dst_old),
  .cond_in   (cond_in),
  .out_valid (out_valid),
  .cond_out  (cond_out),
  .move_out  (move_out),
  .cond_zero (cond_zero),
  .cond_any  (cond_any)
);

// File: tb/simd_cond_unit_tb.sv
module simd_cond_unit_tb;

  localparam int L = 4;
  localparam int W = 3;
  localparam int VW = L * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [3:0]    op = '0;
  logic          is_signed = 1'b0;
  logic          inv = 1'b0;
  logic [VW-1:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [L-1:0]  cond_in = '0;
  logic          out_valid, cond_zero, cond_any;
  logic [L-1:0]  cond_out;
  logic [VW-1:0] move_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_cond_unit #(.LANES(L), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .is_signed(is_signed), .inv(inv), .src_a(src_a), .src_b(src_b),
    .dst_old(dst_old), .cond_in(cond_in), .out_valid(out_valid),
    .cond_out(cond_out), .move_out(move_out), .cond_zero(cond_zero),
    .cond_any(cond_any)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int num(input int v, input bit s);
    if (s && v >= (1 << (W - 1))) return v - (1 << W);
    return v;
  endfunction

  function automatic bit ref_lane(input int a, input int b, input int o, input bit s);
    int x = num(a, s);
    int y = num(b, s);
    case (o)
      0: return x < y;
      1: return x <= y;
      2: return x > y;
      3: return x >= y;
      4: return a != b;
      5: return a == b;
      6: return a == 0;
      7: return a != 0;
      8: return (a & b) == 0;
      9: return (a & b) != 0;
      default: return 1'b0;
    endcase
  endfunction

  // Present one request, then sample one cycle later at the falling edge
  task automatic issue;
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_flags(input string req, input logic [L-1:0] exp_c);
    chk(req, {62'd0, cond_zero, cond_any}, {62'd0, exp_c == '0, exp_c != '0});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [L-1:0]  ec;
    logic [VW-1:0] em;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset", {46'd0, out_valid, cond_out, move_out, cond_zero, cond_any},
        {46'd0, 1'b0, 4'd0, 12'd0, 1'b1, 1'b0});
    rst_n = 1'b1;

    // R1 R2 R3 R9: every operand pair in every lane position, all test opcodes
    for (int o = 0; o < 10; o++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 16; k++) begin
          op = 4'(o);
          is_signed = s[0];
          inv = k[0];
          cond_in = 4'(k);
          ec = '0;
          for (int l = 0; l < L; l++) begin
            int p = (k * L + l + o) % 64;
            src_a[l*W +: W] = 3'(p >> 3);
            src_b[l*W +: W] = 3'(p & 7);
            dst_old[l*W +: W] = 3'(l + k);
            ec[l] = ref_lane(p >> 3, p & 7, o, s[0]);
          end
          em = dst_old;
          issue();
          chk("R1,R2,R3 cond", 64'(cond_out), 64'(ec));
          chk("R9 test keeps dst", 64'(move_out), 64'(em));
          chk("R7 valid", 64'(out_valid), 64'd1);
          check_flags("R6 flags", ec);
        end
      end
    end

    // R4 R5: masked move under every mask and both polarities
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 2; v++) begin
        op = 4'd10;
        inv = v[0];
        cond_in = 4'(m);
        for (int l = 0; l < L; l++) begin
          src_a[l*W +: W] = 3'(l + 1 + m);
          dst_old[l*W +: W] = 3'(6 - l);
          em[l*W +: W] = (m[l] ^ v[0]) ? 3'(l + 1 + m) : 3'(6 - l);
        end
        issue();
        chk(v ? "R5 inverted move" : "R4 move", 64'(move_out), 64'(em));
        chk("R9 mask echo", 64'(cond_out), 64'(m));
        check_flags("R6 flags move", 4'(m));
      end
    end

    // R9: reserved opcodes
    for (int o = 11; o < 16; o++) begin
      op = 4'(o);
      cond_in = 4'hF;
      src_a = 12'hFFF;
      src_b = 12'hFFF;
      dst_old = 12'(o * 37);
      issue();
      chk("R9 reserved cond", 64'(cond_out), 64'd0);
      chk("R9 reserved move", 64'(move_out), 64'(12'(o * 37)));
      check_flags("R6 reserved flags", 4'd0);
    end

    // R8: hold while idle with changing inputs
    op = 4'd10; inv = 1'b0; cond_in = 4'b0101;
    src_a = 12'o7777; dst_old = 12'o1234;
    issue();
    em = move_out;
    ec = cond_out;
    chk("R4 before hold", 64'(em), 64'(12'o1737));
    op = 4'd5; cond_in = 4'b1010; src_a = 12'o0000; src_b = 12'o0000; dst_old = 12'o4321;
    repeat (3) @(negedge clk);
    chk("R8 hold cond", 64'(cond_out), 64'(ec));
    chk("R8 hold move", 64'(move_out), 64'(em));
    chk("R7 idle valid", 64'(out_valid), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule